// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a 32-bit processor core that retires one instruction per clock cycle. Fetch, decode, register read, ALU work, data access, register write-back and next-PC selection all sit in one combinational path between two rising clock edges. The instruction and data memories are separate arrays inside the core, so a fetch and a data access can take place in the same cycle.

The core runs a small instruction subset: word load and store, five register-to-register operations (add, subtract, AND, OR, signed set-on-less-than), branch-if-equal and an absolute jump. The main decoder produces a 2-bit operation class. A second-level decoder turns that class, together with the function field, into a 4-bit ALU operation.

A test port fills the instruction or the data memory while the core is held in reset. Two debug read paths give the contents of any register and of any data-memory word, and the program counter is visible at a port.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high `rst` sets the PC to 0 and clears all 32 registers on the rising edge. While `rst` is high, no register or data-memory write from an instruction takes place.
- R2: An R-type instruction (opcode 0, rs [25:21], rt [20:16], rd [15:11], shift field [10:6] equal to 0) writes rd with the result selected by its function field [5:0]: 0x20 add, 0x22 rs minus rt, 0x24 AND, 0x25 OR, 0x2A signed set-on-less-than (1 if rs < rt, else 0).
- R3: Load word (opcode 35) writes rt with the data word at byte address rs + sign-extended imm[15:0]. Store word (opcode 43) writes rt to that word. Word index = address bits [MEM_AW+1:2].
- R4: Register 0 always reads as zero, and writes to it have no effect.
- R5: Branch-if-equal (opcode 4) sets the next PC to PC+4 + (sign-extended imm << 2) when rs equals rt. Otherwise the next PC is PC+4.
- R6: Jump (opcode 2) sets the next PC to {(PC+4)[31:28], target[25:0], 2'b00}.
- R7: An undefined opcode, or an R-type word with an unsupported function code or a nonzero shift field, writes no register and no memory, and the PC advances by 4.
- R8: Each load, store and R-type instruction completes in one cycle and advances the PC by 4. The preload port (`load_we`, `load_dmem` = 1 selects data memory, 0 instruction memory, `load_addr` as word index) writes memories. `dbg_reg_data` and `dbg_mem_data` combinationally return the selected register and data word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| load_we | input | 1 | Preload write strobe |
| load_dmem | input | 1 | Preload target: 1 data memory, 0 instruction memory |
| load_addr | input | MEM_AW | Preload word index |
| load_data | input | 32 | Preload word |
| dbg_reg_sel | input | 5 | Register number for debug read |
| dbg_reg_data | output | 32 | Contents of selected register |
| dbg_mem_addr | input | MEM_AW | Data-memory word index for debug read |
| dbg_mem_data | output | 32 | Contents of selected data word |
| pc | output | 32 | Current program counter |

## Verification
The main test is a sweep over every ordered pair from a set of operands: zero, one, all ones, the largest positive value, the most negative value and a mixed pattern. Each pair is loaded from data memory and passed through all five ALU operations, a store of each result and a conditional branch. Carry and borrow wrap-around show up in add and subtract, signed versus unsigned comparison in set-on-less-than, and equal versus unequal operands decide whether the branch skips the write that follows it. A directed program then follows the PC cycle by cycle through a negative load/store offset, a write to register 0, an undefined opcode, an unsupported function code, a forward branch that is not taken, a forward branch that is taken, a jump and a backward self-branch.

// File: rtl/sc_core.sv
module sc_core #(
  parameter int MEM_AW = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_we,
  input  logic              load_dmem,
  input  logic [MEM_AW-1:0] load_addr,
  input  logic [31:0]       load_data,
  input  logic [4:0]        dbg_reg_sel,
  output logic [31:0]       dbg_reg_data,
  input  logic [MEM_AW-1:0] dbg_mem_addr,
  output logic [31:0]       dbg_mem_data,
  output logic [31:0]       pc
);
  localparam int DEPTH = 1 << MEM_AW;

  localparam logic [5:0] OP_R   = 6'd0;
  localparam logic [5:0] OP_LW  = 6'd35;
  localparam logic [5:0] OP_SW  = 6'd43;
  localparam logic [5:0] OP_BEQ = 6'd4;
  localparam logic [5:0] OP_J   = 6'd2;

  localparam logic [1:0] CLS_MEM = 2'b00;
  localparam logic [1:0] CLS_BR  = 2'b01;
  localparam logic [1:0] CLS_R   = 2'b10;

  localparam logic [3:0] ALU_AND = 4'b0000;
  localparam logic [3:0] ALU_OR  = 4'b0001;
  localparam logic [3:0] ALU_ADD = 4'b0010;
  localparam logic [3:0] ALU_SUB = 4'b0110;
  localparam logic [3:0] ALU_SLT = 4'b0111;
  localparam logic [3:0] ALU_NOR = 4'b1100;

  logic [31:0] imem [DEPTH];
  logic [31:0] dmem [DEPTH];
  logic [31:0] rf   [32];

  logic [31:0] instr;
  logic [5:0]  opc;
  logic [4:0]  rs, rt, rd;
  logic [31:0] simm;
  logic [31:0] rs_val, rt_val;

  assign instr = imem[pc[MEM_AW+1:2]];
  assign opc   = instr[31:26];
  assign rs    = instr[25:21];
  assign rt    = instr[20:16];
  assign rd    = instr[15:11];
  assign simm  = {{16{instr[15]}}, instr[15:0]};

  assign rs_val = (rs == 5'd0) ? 32'd0 : rf[rs];
  assign rt_val = (rt == 5'd0) ? 32'd0 : rf[rt];

  logic       reg_dst, alu_imm, mem_to_reg, reg_we, mem_we, branch, jump;
  logic [1:0] alu_cls;

  always_comb begin
    reg_dst    = 1'b0;
    alu_imm    = 1'b0;
    mem_to_reg = 1'b0;
    reg_we     = 1'b0;
    mem_we     = 1'b0;
    branch     = 1'b0;
    jump       = 1'b0;
    alu_cls    = CLS_MEM;
    case (opc)
      OP_R: begin
        reg_dst = 1'b1;
        reg_we  = 1'b1;
        alu_cls = CLS_R;
      end
      OP_LW: begin
        alu_imm    = 1'b1;
        mem_to_reg = 1'b1;
        reg_we     = 1'b1;
      end
      OP_SW: begin
        alu_imm = 1'b1;
        mem_we  = 1'b1;
      end
      OP_BEQ: begin
        branch  = 1'b1;
        alu_cls = CLS_BR;
      end
      OP_J: jump = 1'b1;
      default: ;
    endcase
  end

  logic [3:0] alu_op;
  logic       funct_ok;

  always_comb begin
    alu_op   = ALU_ADD;
    funct_ok = 1'b1;
    case (alu_cls)
      CLS_MEM: alu_op = ALU_ADD;
      CLS_BR:  alu_op = ALU_SUB;
      CLS_R: begin
        case (instr[5:0])
          6'h20:   alu_op = ALU_ADD;
          6'h22:   alu_op = ALU_SUB;
          6'h24:   alu_op = ALU_AND;
          6'h25:   alu_op = ALU_OR;
          6'h2A:   alu_op = ALU_SLT;
          default: funct_ok = 1'b0;
        endcase
        if (instr[10:6] != 5'd0) funct_ok = 1'b0;
      end
      default: funct_ok = 1'b0;
    endcase
  end

  logic [31:0] alu_b, alu_res;
  logic        alu_zero;

  assign alu_b = alu_imm ? simm : rt_val;

  always_comb begin
    case (alu_op)
      ALU_AND: alu_res = rs_val & alu_b;
      ALU_OR:  alu_res = rs_val | alu_b;
      ALU_ADD: alu_res = rs_val + alu_b;
      ALU_SUB: alu_res = rs_val - alu_b;
      ALU_SLT: alu_res = {31'd0, $signed(rs_val) < $signed(alu_b)};
      ALU_NOR: alu_res = ~(rs_val | alu_b);
      default: alu_res = 32'd0;
    endcase
  end
  assign alu_zero = (alu_res == 32'd0);

  logic [MEM_AW-1:0] daddr;
  logic [31:0]       wb_data;
  logic [4:0]        wb_idx;
  logic              wb_en;

  assign daddr   = alu_res[MEM_AW+1:2];
  assign wb_data = mem_to_reg ? dmem[daddr] : alu_res;
  assign wb_idx  = reg_dst ? rd : rt;
  assign wb_en   = reg_we && funct_ok && (wb_idx != 5'd0);

  logic [31:0] pc4, pc_br, pc_jmp, pc_next;

  assign pc4     = pc + 32'd4;
  assign pc_br   = pc4 + {simm[29:0], 2'b00};
  assign pc_jmp  = {pc4[31:28], instr[25:0], 2'b00};
  assign pc_next = jump ? pc_jmp : (branch && alu_zero) ? pc_br : pc4;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= 32'd0;
      for (int i = 0; i < 32; i++) rf[i] <= 32'd0;
    end else begin
      pc <= pc_next;
      if (wb_en) rf[wb_idx] <= wb_data;
    end
  end

  always_ff @(posedge clk) begin
    if (load_we && load_dmem) dmem[load_addr] <= load_data;
    else if (!rst && mem_we) dmem[daddr] <= rt_val;
  end

  always_ff @(posedge clk) begin
    if (load_we && !load_dmem) imem[load_addr] <= load_data;
  end

  assign dbg_reg_data = (dbg_reg_sel == 5'd0) ? 32'd0 : rf[dbg_reg_sel];
  assign dbg_mem_data = dmem[dbg_mem_addr];
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic [31:0] instr,
  input logic [31:0] rs_val,
  input logic [31:0] rt_val,
  input logic [4:0]  dbg_reg_sel,
  input logic [31:0] dbg_reg_data
);
  logic [31:0] pc4, br_tgt, jmp_tgt;
  logic [5:0]  opc;

  assign opc     = instr[31:26];
  assign pc4     = pc + 32'd4;
  assign br_tgt  = pc4 + {{14{instr[15]}}, instr[15:0], 2'b00};
  assign jmp_tgt = {pc4[31:28], instr[25:0], 2'b00};

  // R1
  reset_pc_chk: assert property (@(posedge clk) rst |=> pc == 32'd0);

  // R4
  zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
    dbg_reg_sel == 5'd0 |-> dbg_reg_data == 32'd0);

  // R8
  step_pc_chk: assert property (@(posedge clk) disable iff (rst)
    (opc != 6'd4 && opc != 6'd2) |=> pc == $past(pc4));

  // R6
  jump_pc_chk: assert property (@(posedge clk) disable iff (rst)
    opc == 6'd2 |=> pc == $past(jmp_tgt));

  // R5
  beq_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (opc == 6'd4 && rs_val == rt_val) |=> pc == $past(br_tgt));

  // R5
  beq_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (opc == 6'd4 && rs_val != rt_val) |=> pc == $past(pc4));
endmodule

bind sc_core sc_core_chk u_chk (
  .clk(clk), .rst(rst), .pc(pc), .instr(instr),
  .rs_val(rs_val), .rt_val(rt_val),
  .dbg_reg_sel(dbg_reg_sel), .dbg_reg_data(dbg_reg_data)
);

// File: tb/sc_core_tb.sv
module sc_core_tb;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          load_we = 1'b0;
  logic          load_dmem = 1'b0;
  logic [AW-1:0] load_addr = '0;
  logic [31:0]   load_data = '0;
  logic [4:0]    dbg_reg_sel = '0;
  logic [31:0]   dbg_reg_data;
  logic [AW-1:0] dbg_mem_addr = '0;
  logic [31:0]   dbg_mem_data;
  logic [31:0]   pc;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sc_core #(.MEM_AW(AW)) u_dut (
    .clk(clk), .rst(rst), .load_we(load_we), .load_dmem(load_dmem),
    .load_addr(load_addr), .load_data(load_data),
    .dbg_reg_sel(dbg_reg_sel), .dbg_reg_data(dbg_reg_data),
    .dbg_mem_addr(dbg_mem_addr), .dbg_mem_data(dbg_mem_data), .pc(pc)
  );

  function automatic logic [31:0] enc_r(int s, int t, int d, logic [5:0] f);
    return {6'd0, 5'(s), 5'(t), 5'(d), 5'd0, f};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int s, int t, int imm);
    return {op, 5'(s), 5'(t), 16'(imm)};
  endfunction
  function automatic logic [31:0] enc_j(int tgt);
    return {6'd2, 26'(tgt)};
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic load(bit to_d, int idx, logic [31:0] w);
    @(negedge clk);
    load_we = 1'b1; load_dmem = to_d; load_addr = AW'(idx); load_data = w;
    @(negedge clk);
    load_we = 1'b0;
  endtask

  task automatic reg_is(string req, int r, logic [31:0] exp);
    dbg_reg_sel = 5'(r); #1;
    check(req, $sformatf("r%0d", r), dbg_reg_data, exp);
  endtask

  task automatic mem_is(string req, int w, logic [31:0] exp);
    dbg_mem_addr = AW'(w); #1;
    check(req, $sformatf("dmem[%0d]", w), dbg_mem_data, exp);
  endtask

  task automatic enter_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  logic [31:0] vals [6] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
                            32'h8000_0000, 32'h1234_5678};

  logic [31:0] trace [12] = '{32'd0, 32'd4, 32'd8, 32'd12, 32'd16, 32'd20,
                              32'd24, 32'd28, 32'd40, 32'd80, 32'd84, 32'd84};

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "pc in reset", pc, 32'd0);
    for (int r = 0; r < 32; r++) reg_is("R1", r, 32'd0);

    // Sweep: R2, R3, R5, R8
    for (int i = 0; i < 6; i++) begin
      for (int j = 0; j < 6; j++) begin
        logic [31:0] a, b, sl;
        a = vals[i]; b = vals[j];
        sl = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        enter_reset();
        load(1, 0, a);
        load(1, 1, b);
        load(0, 0,  enc_i(6'd35, 0, 1, 0));
        load(0, 1,  enc_i(6'd35, 0, 2, 4));
        load(0, 2,  enc_r(1, 2, 3, 6'h20));
        load(0, 3,  enc_r(1, 2, 4, 6'h22));
        load(0, 4,  enc_r(1, 2, 5, 6'h24));
        load(0, 5,  enc_r(1, 2, 6, 6'h25));
        load(0, 6,  enc_r(1, 2, 7, 6'h2A));
        load(0, 7,  enc_i(6'd43, 0, 3, 8));
        load(0, 8,  enc_i(6'd43, 0, 4, 12));
        load(0, 9,  enc_i(6'd43, 0, 5, 16));
        load(0, 10, enc_i(6'd43, 0, 6, 20));
        load(0, 11, enc_i(6'd43, 0, 7, 24));
        load(0, 12, enc_i(6'd4, 1, 2, 1));
        load(0, 13, enc_r(1, 1, 8, 6'h20));
        load(0, 14, enc_j(14));
        @(negedge clk); rst = 1'b0;
        repeat (20) @(negedge clk);
        reg_is("R3", 1, a);
        reg_is("R2", 3, a + b);
        reg_is("R2", 4, a - b);
        reg_is("R2", 5, a & b);
        reg_is("R2", 6, a | b);
        reg_is("R2", 7, sl);
        mem_is("R3", 2, a + b);
        mem_is("R3", 3, a - b);
        mem_is("R3", 4, a & b);
        mem_is("R3", 5, a | b);
        mem_is("R3", 6, sl);
        reg_is("R5", 8, (a == b) ? 32'd0 : a + a);
        check("R6", "pc parked", pc, 32'd56);
      end
    end

    // Directed program: R3, R4, R5, R6, R7, R8
    enter_reset();
    load(1, 4, 32'h55);
    load(1, 5, 32'd20);
    load(1, 3, 32'hDEAD_BEEF);
    load(0, 0,  enc_i(6'd35, 0, 3, 20));
    load(0, 1,  enc_i(6'd35, 3, 2, -4));
    load(0, 2,  enc_i(6'd43, 3, 2, -8));
    load(0, 3,  enc_r(2, 2, 0, 6'h20));
    load(0, 4,  enc_i(6'd8, 0, 4, 7));
    load(0, 5,  enc_r(2, 2, 5, 6'h27));
    load(0, 6,  enc_i(6'd4, 2, 3, 5));
    load(0, 7,  enc_i(6'd4, 0, 0, 2));
    load(0, 8,  enc_r(2, 2, 6, 6'h20));
    load(0, 9,  enc_r(2, 2, 6, 6'h20));
    load(0, 10, enc_j(20));
    load(0, 11, enc_r(2, 2, 7, 6'h20));
    load(0, 20, enc_r(2, 3, 8, 6'h20));
    load(0, 21, enc_i(6'd4, 0, 0, -1));
    @(negedge clk); rst = 1'b0; #1;
    for (int k = 0; k < 12; k++) begin
      if (k > 0) begin @(negedge clk); #1; end
      check("R8", $sformatf("pc trace step %0d", k), pc, trace[k]);
    end
    reg_is("R3", 3, 32'd20);
    reg_is("R3", 2, 32'h55);
    mem_is("R3", 3, 32'h55);
    reg_is("R4", 0, 32'd0);
    reg_is("R7", 4, 32'd0);
    reg_is("R7", 5, 32'd0);
    reg_is("R5", 6, 32'd0);
    reg_is("R6", 7, 32'd0);
    reg_is("R8", 8, 32'h69);

    // R1: no writes while held in reset
    @(negedge clk); rst = 1'b1;
    @(negedge clk); #1;
    check("R1", "pc after re-reset", pc, 32'd0);
    reg_is("R1", 8, 32'd0);
    mem_is("R1", 3, 32'h55);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule